// File: doc/BRIEF.md
# Pipelined Converter Code Alignment and Correction

This block is the digital back end of a multi-stage pipelined analog-to-digital converter. Four coarse stages each produce a 3-bit code, and a final stage produces a 4-bit code. Every stage starts work on a new sample as soon as it hands its residue on. In any clock the codes at the inputs therefore belong to different samples: stage k carries the sample that entered the pipeline k-1 cycles earlier, and the final stage runs in the same cycle as stage 4.

The block delays each coarse code by just enough cycles that all five codes of one sample meet in the same cycle. It then adds them with weights that overlap by one bit and subtracts a fixed bias, which yields a 12-bit result. Because the x4 interstage gain leaves one redundant bit per coarse stage, a coarse decision that is one step off is cancelled by the following stage. The result is clamped to the output range and registered. A valid flag presented with the stage-1 code travels with its sample, so a new result can come out on every clock.

Top module: `pipe_adc_corrector`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid is 0 and out_data is 0.
- R2: The codes of one sample are combined: the stage-1 code is presented with in_valid in cycle s, the stage-k code in cycle s+k-1, and the final code in cycle s+3. stage_codes bits [3k-1:3k-3] carry stage k.
- R3: The result equals c1*512 + c2*128 + c3*32 + c4*8 + f - 680, where ck is the stage-k code and f the final code. In terms of shifts, stage k is shifted left by 3+2*(4-k) and f is not shifted.
- R4: Each ideal code ck = 2*dk+1, where dk is the 2-bit digit at bits [13-2k:12-2k] of a value x, together with f = x[3:0], gives out_data = x. The result also stays x if one unit is added to ck and 4 units are taken off c(k+1), or, for k = 4, if 8 units are taken off f.
- R5: A result below zero is output as 0.
- R6: A result above 4095 is output as 4095, and all codes at their maximum (7,7,7,7,15) give exactly 4095.
- R7: out_valid rises exactly 5 cycles after the cycle in which in_valid is presented with the stage-1 code.
- R8: While out_valid is 0, out_data keeps the last result. Codes of samples without in_valid never reach it.
- R9: Samples presented on consecutive cycles give results on consecutive cycles, one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a new sample; presented with its stage-1 code |
| stage_codes | input | 12 | Coarse codes, stage 1 in the lowest 3 bits |
| final_code | input | 4 | Code of the final 4-bit stage |
| out_valid | output | 1 | Result valid |
| out_data | output | 12 | Corrected, clamped result |

## Verification
Ideal codes derived from chosen values show that the weights and the bias are right, because the output must return the original value exactly. Pairs of codes that carry a deliberate one-step error in each coarse stage, offset in the next stage, show that the redundancy cancels the error rather than passing it through. All-zero and all-maximum codes test the two clamp edges. Random codes, with gaps in valid and runs of back-to-back samples, expose misaligned delays, because a wrong delay mixes codes from neighbouring samples. The gaps also show whether the output holds its value.

// File: rtl/pipe_adc_pkg.sv
package pipe_adc_pkg;

  // Left shift applied to the code of coarse stage k (1-based).
  function automatic int stage_shift(int k, int n_stages, int eff_bits, int final_w);
    return final_w - 1 + eff_bits * (n_stages - k);
  endfunction

  // Bias removed from the sum: one unit at each coarse stage's weight.
  function automatic int redundancy_bias(int n_stages, int eff_bits, int final_w);
    int acc;
    acc = 0;
    for (int k = 1; k <= n_stages; k++) begin
      acc = acc + (1 << stage_shift(k, n_stages, eff_bits, final_w));
    end
    return acc;
  endfunction

endpackage

// File: rtl/adc_code_delay.sv
module adc_code_delay #(
  parameter int W     = 3,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] taps [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
    end else begin
      taps[0] <= din;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end

  assign dout = taps[DEPTH-1];
endmodule

// File: rtl/adc_overlap_sum.sv
module adc_overlap_sum #(
  parameter int NUM_STAGES = 4,
  parameter int STAGE_W    = 3,
  parameter int FINAL_W    = 4,
  parameter int EFF_BITS   = 2,
  parameter int SUM_W      = 15,
  parameter int BIAS       = 680
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          vld_in,
  input  logic [NUM_STAGES*STAGE_W-1:0] codes,
  input  logic [FINAL_W-1:0]            final_code,
  output logic signed [SUM_W-1:0]       sum_q,
  output logic                          sum_vld
);
  logic signed [SUM_W-1:0] acc;

  always_comb begin
    acc = '0 - SUM_W'(BIAS);
    for (int k = 0; k < NUM_STAGES; k++) begin
      acc = acc + (SUM_W'(codes[k*STAGE_W +: STAGE_W])
                   << pipe_adc_pkg::stage_shift(k + 1, NUM_STAGES, EFF_BITS, FINAL_W));
    end
    acc = acc + SUM_W'(final_code);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      sum_vld <= 1'b0;
    end else begin
      sum_vld <= vld_in;
      if (vld_in) sum_q <= acc;
    end
  end
endmodule

// File: rtl/adc_clamp_reg.sv
module adc_clamp_reg #(
  parameter int SUM_W = 15,
  parameter int OUT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vld_in,
  input  logic signed [SUM_W-1:0] sum_in,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_data
);
  localparam int MAXV = (1 << OUT_W) - 1;

  logic [OUT_W-1:0] clamped;

  always_comb begin
    if (sum_in[SUM_W-1])                       clamped = '0;
    else if ($unsigned(sum_in) > SUM_W'(MAXV)) clamped = OUT_W'(MAXV);
    else                                       clamped = sum_in[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= vld_in;
      if (vld_in) out_data <= clamped;
    end
  end
endmodule

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector #(
  parameter int NUM_STAGES = 4,
  parameter int STAGE_W    = 3,
  parameter int FINAL_W    = 4,
  parameter int EFF_BITS   = 2,
  parameter int OUT_W      = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [NUM_STAGES*STAGE_W-1:0] stage_codes,
  input  logic [FINAL_W-1:0]            final_code,
  output logic                          out_valid,
  output logic [OUT_W-1:0]              out_data
);
  localparam int SUM_W = OUT_W + STAGE_W;
  localparam int BIAS  = pipe_adc_pkg::redundancy_bias(NUM_STAGES, EFF_BITS, FINAL_W);

  logic [NUM_STAGES*STAGE_W-1:0] aligned_codes;
  logic                          aligned_valid;
  logic signed [SUM_W-1:0]       sum_q;
  logic                          sum_vld;

  // Stage k (index k-1) waits NUM_STAGES-k cycles; the last coarse stage waits none.
  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_align
    if (NUM_STAGES - 1 - k == 0) begin : g_direct
      assign aligned_codes[k*STAGE_W +: STAGE_W] = stage_codes[k*STAGE_W +: STAGE_W];
    end else begin : g_delay
      adc_code_delay #(.W(STAGE_W), .DEPTH(NUM_STAGES - 1 - k)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .din  (stage_codes[k*STAGE_W +: STAGE_W]),
        .dout (aligned_codes[k*STAGE_W +: STAGE_W])
      );
    end
  end

  if (NUM_STAGES == 1) begin : g_vld_direct
    assign aligned_valid = in_valid;
  end else begin : g_vld_delay
    adc_code_delay #(.W(1), .DEPTH(NUM_STAGES - 1)) u_vdly (
      .clk  (clk),
      .rst  (rst),
      .din  (in_valid),
      .dout (aligned_valid)
    );
  end

  adc_overlap_sum #(
    .NUM_STAGES(NUM_STAGES), .STAGE_W(STAGE_W), .FINAL_W(FINAL_W),
    .EFF_BITS(EFF_BITS), .SUM_W(SUM_W), .BIAS(BIAS)
  ) u_sum (
    .clk        (clk),
    .rst        (rst),
    .vld_in     (aligned_valid),
    .codes      (aligned_codes),
    .final_code (final_code),
    .sum_q      (sum_q),
    .sum_vld    (sum_vld)
  );

  adc_clamp_reg #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_clamp (
    .clk       (clk),
    .rst       (rst),
    .vld_in    (sum_vld),
    .sum_in    (sum_q),
    .out_valid (out_valid),
    .out_data  (out_data)
  );
endmodule

// File: rtl/pipe_adc_corrector_chk.sv
module pipe_adc_corrector_chk #(
  parameter int NUM_STAGES = 4,
  parameter int SUM_W      = 15,
  parameter int OUT_W      = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic signed [SUM_W-1:0] sum_q,
  input logic                    sum_vld,
  input logic                    out_valid,
  input logic [OUT_W-1:0]        out_data
);
  localparam int LAT  = NUM_STAGES + 1;
  localparam int MAXV = (1 << OUT_W) - 1;

  logic [LAT-1:0] vpipe;

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-2:0], in_valid};
  end

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_data == '0));

  a_r7_valid_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == vpipe[LAT-1]);

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

  a_r5_clamp_low: assert property (@(posedge clk) disable iff (rst)
    (sum_vld && sum_q[SUM_W-1]) |=> (out_data == '0));

  a_r6_clamp_high: assert property (@(posedge clk) disable iff (rst)
    (sum_vld && !sum_q[SUM_W-1] && $unsigned(sum_q) > SUM_W'(MAXV))
      |=> (out_data == OUT_W'(MAXV)));

  a_r3_in_range: assert property (@(posedge clk) disable iff (rst)
    (sum_vld && !sum_q[SUM_W-1] && $unsigned(sum_q) <= SUM_W'(MAXV))
      |=> (out_valid && out_data == $past(sum_q[OUT_W-1:0])));
endmodule

bind pipe_adc_corrector pipe_adc_corrector_chk #(
  .NUM_STAGES(NUM_STAGES), .SUM_W(SUM_W), .OUT_W(OUT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .sum_q     (sum_q),
  .sum_vld   (sum_vld),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/pipe_adc_corrector_tb.sv
module pipe_adc_corrector_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAXS = 160;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] stage_codes = '0;
  logic [3:0]  final_code = '0;
  logic        out_valid;
  logic [11:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;

  int sc [MAXS][4];
  int sf [MAXS];
  int sv [MAXS];
  int sx [MAXS];
  string stag [MAXS];
  int ns = 0;

  pipe_adc_corrector u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .stage_codes(stage_codes),
    .final_code(final_code), .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int formula(int c1, int c2, int c3, int c4, int f);
    int v;
    v = c1 * 512 + c2 * 128 + c3 * 32 + c4 * 8 + f - 680;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic add_raw(int c1, int c2, int c3, int c4, int f, int v, string tag);
    sc[ns][0] = c1; sc[ns][1] = c2; sc[ns][2] = c3; sc[ns][3] = c4;
    sf[ns] = f; sv[ns] = v; stag[ns] = tag;
    sx[ns] = formula(c1, c2, c3, c4, f);
    ns++;
  endtask

  // Ideal codes for value x, with optional one-step error in stage k (1..4) offset downstream.
  task automatic add_ideal(int x, int k, int e, string tag);
    int c [4];
    int f;
    for (int i = 0; i < 4; i++) c[i] = 2 * ((x >> (10 - 2 * i)) & 3) + 1;
    f = x & 15;
    if (k >= 1 && k <= 3) begin
      c[k-1] += e; c[k] -= 4 * e;
    end else if (k == 4) begin
      c[3] += e; f -= 8 * e;
    end
    add_raw(c[0], c[1], c[2], c[3], f, 1, tag);
    sx[ns-1] = x;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int held;
    int s;
    // R3 ideal values
    add_ideal(0, 0, 0, "R3");
    add_raw(5, 6, 1, 2, 9, 0, "R8");
    add_ideal(2048, 0, 0, "R3");
    add_raw(7, 7, 7, 7, 15, 0, "R8");
    add_raw(0, 0, 0, 0, 0, 0, "R8");
    add_ideal(1234, 0, 0, "R3");
    // R9 back-to-back burst
    add_ideal(1, 0, 0, "R9");
    add_ideal(4095, 0, 0, "R9");
    add_ideal(3000, 0, 0, "R9");
    add_ideal(77, 0, 0, "R9");
    // R4 redundancy: x = 0x668 with errors in each stage
    add_ideal(12'h668, 0, 0, "R4");
    add_ideal(12'h668, 1, 1, "R4");
    add_ideal(12'h668, 2, -1, "R4");
    add_ideal(12'h668, 3, 1, "R4");
    add_ideal(12'h668, 4, 1, "R4");
    // R5 clamp low
    add_raw(0, 0, 0, 0, 0, 1, "R5");
    add_raw(0, 0, 0, 0, 15, 1, "R5");
    add_raw(1, 0, 0, 0, 0, 1, "R5");
    // R6 top of range
    add_raw(7, 7, 7, 7, 15, 1, "R6");
    // R2 random codes, random valid
    for (int i = 0; i < 60; i++) begin
      add_raw($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
              $urandom_range(0, 7), $urandom_range(0, 15),
              ($urandom_range(0, 4) != 0) ? 1 : 0, "R2");
    end

    // Reset: R1
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(out_data == 12'd0, "R1", out_data, 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(out_data == 12'd0, "R1", out_data, 0);

    held = 0;
    for (int t = 0; t < ns + 8; t++) begin
      @(negedge clk);
      // compare
      s = t - 5;
      if (s >= 0 && s < ns && sv[s] != 0) begin
        held = sx[s];
        check(out_valid == 1'b1, "R7", out_valid, 1);
        check(out_data == 12'(held), stag[s], out_data, held);
      end else begin
        check(out_valid == 1'b0, "R7", out_valid, 0);
        check(out_data == 12'(held), "R8", out_data, held);
      end
      // drive
      for (int k = 1; k <= 4; k++) begin
        int idx;
        idx = t - (k - 1);
        stage_codes[(k-1)*3 +: 3] = (idx >= 0 && idx < ns) ? 3'(sc[idx][k-1]) : 3'd0;
      end
      final_code = (t - 3 >= 0 && t - 3 < ns) ? 4'(sf[t-3]) : 4'd0;
      in_valid   = (t < ns) ? (sv[t] != 0) : 1'b0;
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule